// File: doc/BRIEF.md
# Two-Channel Peripheral DMA Controller

This block moves data between two peripheral FIFOs and memory, one FIFO per channel. Software programs a channel through a 32-bit register port. It writes a configuration word, a start address and a byte length, then writes 1 to that channel's run register. The channel runs in one of two directions. In receive direction, each word taken from the FIFO becomes a memory write. In transmit direction, each memory read is handed to the FIFO. While a channel runs, its current-address register climbs and its current-length register falls. At any time the bytes already moved equal the programmed length minus the current length.

The channel finishes when its current address equals the start address plus the length. At that point the run register drops to 0 and the channel's end-of-transfer status bit sets. An interrupt is raised when that status bit is enabled. The two channels share one memory request port through a round-robin arbiter. A configurable number of idle cycles can be placed between the bus requests of a channel. In receive-end mode a channel stops early on a word marked as last.

Top module: `dma2ch_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `mem_req` is 0.
- R2: Channel 0 registers sit at these offsets: config 0x00, start address 0x10, length 0x18, current address 0x20, current length 0x28, run 0x30. Channel 1 uses the same offsets plus 0x04. Config bit 12 selects transmit direction (memory to FIFO; 0 selects FIFO to memory). Config bit 8 selects receive-end mode. Config bits 5:4 hold the wait count. Written values read back.
- R3: Writing the run register with bit 0 set while the channel is idle starts it. The start copies the start address and length into the current registers, and the run register then reads 1.
- R4: In receive direction, each accepted FIFO word is written to memory at the current address. Each beat moves n = min(4, remaining) bytes, with byte enables set on the low n bits. The current address grows by n and the current length falls by n.
- R5: In transmit direction, a memory read is requested only while the FIFO is ready. The read data goes out on `tx_data` with that channel's `tx_valid` in the cycle of `mem_ack`.
- R6: When the current address equals the start address plus the length, the run register reads 0 and the status bit sets. The status bits are at 0x44, with bit 0 for channel 0 and bit 1 for channel 1. A zero length completes with no bus request.
- R7: `irq` is the OR over channels of status AND enable, with the enable register at 0x40 using the same bit order. A status bit stays set until 1 is written to its bit at 0x48, even after a write of 0 to the run register. If completion and clear fall in the same cycle, the bit stays set.
- R8: Writing 0 to a busy channel's run register stops it on the next edge. The stop issues no further requests, does not set status, and leaves the current length unchanged.
- R9: In receive-end mode, an accepted receive word with `rx_last` high ends the transfer and sets status. The current registers then show the bytes not moved.
- R10: A wait count W puts exactly W idle cycles between two accepted beats of the channel.
- R11: Writes to config, start address or length are ignored while the channel is busy.
- R12: When both channels request, grants alternate between them on each accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Transfer-end interrupt |
| mem_req | output | 1 | Memory beat request |
| mem_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat byte address |
| mem_be | output | 4 | Byte enables of the beat |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Beat accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| rx_valid | input | 2 | Per-channel receive word available |
| rx_last | input | 2 | Per-channel receive word is last |
| rx_data | input | 64 | Receive words, channel c at bits 32c+31:32c |
| rx_ready | output | 2 | Receive word taken |
| tx_valid | output | 2 | Transmit word delivered |
| tx_data | output | 32 | Transmit word |
| tx_ready | input | 2 | Per-channel transmit FIFO has room |

## Verification
The end-of-transfer status set and a software write-one-to-clear can land on the same clock edge. Software can clear a status bit at the very moment the channel sets it. The bench starts a one-beat receive transfer and times the clear write so that it takes effect on the edge where the address comparison completes. It then requires the status bit to read 1 and the run register to read 0. A second collision, with both channels requesting in the same cycle, is judged by requiring successive accepted beats to alternate between channels.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int NUM_CH  = 2;
  localparam int AW      = 32;
  localparam int DW      = 32;
  localparam int CNT_W   = 26;
  localparam int WAIT_W  = 2;
  localparam int BEAT_B  = DW / 8;
  localparam int RAW     = 8;
  localparam int CFG_TX_BIT  = 12;
  localparam int CFG_END_BIT = 8;
  localparam int CFG_WT_LSB  = 4;

  localparam logic [RAW-1:0] OFS_CFG  = 8'h00;
  localparam logic [RAW-1:0] OFS_BASE = 8'h10;
  localparam logic [RAW-1:0] OFS_LEN  = 8'h18;
  localparam logic [RAW-1:0] OFS_CUR  = 8'h20;
  localparam logic [RAW-1:0] OFS_REM  = 8'h28;
  localparam logic [RAW-1:0] OFS_RUN  = 8'h30;
  localparam logic [RAW-1:0] OFS_IEN  = 8'h40;
  localparam logic [RAW-1:0] OFS_ISTS = 8'h44;
  localparam logic [RAW-1:0] OFS_ICLR = 8'h48;
  localparam int CH_STRIDE = 4;

  typedef struct packed {
    logic              tx;
    logic              end_on_last;
    logic [WAIT_W-1:0] gap;
  } chan_cfg_t;

  function automatic chan_cfg_t cfg_unpack(input logic [DW-1:0] w);
    chan_cfg_t c;
    c.tx          = w[CFG_TX_BIT];
    c.end_on_last = w[CFG_END_BIT];
    c.gap         = w[CFG_WT_LSB +: WAIT_W];
    return c;
  endfunction

  function automatic logic [DW-1:0] cfg_pack(input chan_cfg_t c);
    logic [DW-1:0] w;
    w = '0;
    w[CFG_TX_BIT]             = c.tx;
    w[CFG_END_BIT]            = c.end_on_last;
    w[CFG_WT_LSB +: WAIT_W]   = c.gap;
    return w;
  endfunction

  function automatic logic [RAW-1:0] ch_ofs(input int ch, input logic [RAW-1:0] ofs);
    return ofs + RAW'(ch * CH_STRIDE);
  endfunction
endpackage

// File: rtl/dmac_arb.sv
module dmac_arb #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         acc,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q, last_d, pick;
  logic          found;
  int            idx;

  always_comb begin
    gnt   = '0;
    pick  = last_q;
    found = 1'b0;
    idx   = 0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(last_q) + 1 + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        pick     = IW'(idx);
        found    = 1'b1;
      end
    end
    last_d = ((|req) && acc) ? pick : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_d;
  end

  // R12
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ($countones(gnt) == 1));
  // R12
  rr_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&req) && acc) |=> (!(&req) || (gnt != $past(gnt))));
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              base_we,
  input  logic              len_we,
  input  logic              run_we,
  input  logic [DW-1:0]     wdata,
  input  logic              beat_acc,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic              tx_ready,
  output logic              req,
  output logic              req_write,
  output logic [AW-1:0]     req_addr,
  output logic [BEAT_B-1:0] req_be,
  output logic              busy,
  output logic              done,
  output chan_cfg_t         cfg,
  output logic [AW-1:0]     base,
  output logic [CNT_W-1:0]  len,
  output logic [AW-1:0]     cur_addr,
  output logic [CNT_W-1:0]  cur_len
);
  localparam int SZ_W = $clog2(BEAT_B) + 1;

  chan_cfg_t         cfg_q, cfg_d;
  logic [AW-1:0]     base_q, base_d, cur_q, cur_d;
  logic [CNT_W-1:0]  len_q, len_d, rem_q, rem_d;
  logic              busy_q, busy_d, short_q, short_d;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d;
  logic [SZ_W-1:0]   beat_sz;
  logic [AW-1:0]     end_addr;
  logic              reached, finish, start, halt, peer_ok;

  assign end_addr = base_q + AW'(len_q);
  assign reached  = (cur_q == end_addr);
  assign finish   = busy_q && (reached || short_q);
  assign start    = run_we && wdata[0] && !busy_q;
  assign halt     = run_we && !wdata[0] && busy_q;
  assign peer_ok  = cfg_q.tx ? tx_ready : rx_valid;

  always_comb begin
    if (rem_q >= CNT_W'(BEAT_B)) beat_sz = SZ_W'(BEAT_B);
    else                         beat_sz = rem_q[SZ_W-1:0];
    for (int b = 0; b < BEAT_B; b++) req_be[b] = (SZ_W'(b) < beat_sz);
  end

  assign req       = busy_q && !reached && !short_q && (wcnt_q == '0) && peer_ok;
  assign req_write = !cfg_q.tx;
  assign req_addr  = cur_q;

  always_comb begin
    cfg_d   = cfg_q;
    base_d  = base_q;
    len_d   = len_q;
    busy_d  = busy_q;
    cur_d   = cur_q;
    rem_d   = rem_q;
    short_d = short_q;
    wcnt_d  = wcnt_q;
    if (!busy_q && cfg_we)  cfg_d  = cfg_unpack(wdata);
    if (!busy_q && base_we) base_d = wdata[AW-1:0];
    if (!busy_q && len_we)  len_d  = wdata[CNT_W-1:0];
    if (wcnt_q != '0) wcnt_d = wcnt_q - 1'b1;
    if (start) begin
      busy_d  = 1'b1;
      cur_d   = base_q;
      rem_d   = len_q;
      short_d = 1'b0;
      wcnt_d  = '0;
    end else begin
      if (halt || finish) begin
        busy_d  = 1'b0;
        short_d = 1'b0;
      end
      if (beat_acc) begin
        cur_d  = cur_q + AW'(beat_sz);
        rem_d  = rem_q - CNT_W'(beat_sz);
        wcnt_d = cfg_q.gap;
        if (!cfg_q.tx && cfg_q.end_on_last && rx_last) short_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      base_q  <= '0;
      len_q   <= '0;
      busy_q  <= 1'b0;
      cur_q   <= '0;
      rem_q   <= '0;
      short_q <= 1'b0;
      wcnt_q  <= '0;
    end else begin
      cfg_q   <= cfg_d;
      base_q  <= base_d;
      len_q   <= len_d;
      busy_q  <= busy_d;
      cur_q   <= cur_d;
      rem_q   <= rem_d;
      short_q <= short_d;
      wcnt_q  <= wcnt_d;
    end
  end

  assign busy     = busy_q;
  assign done     = finish;
  assign cfg      = cfg_q;
  assign base     = base_q;
  assign len      = len_q;
  assign cur_addr = cur_q;
  assign cur_len  = rem_q;

  // R4
  addr_len_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((cur_q - base_q) + AW'(rem_q) == AW'(len_q)));
  // R6
  finish_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy_q);
  // R8
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!busy_q && !req));
  // R10
  gap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_acc && (cfg_q.gap != '0)) |=> !req);
  // R11
  prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !finish && !halt) |=> ($stable(base_q) && $stable(len_q) && $stable(cfg_q)));
endmodule

// File: rtl/dma2ch_ctrl.sv
module dma2ch_ctrl
  import dmac_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [RAW-1:0]       reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic                 irq,
  output logic                 mem_req,
  output logic                 mem_write,
  output logic [AW-1:0]        mem_addr,
  output logic [BEAT_B-1:0]    mem_be,
  output logic [DW-1:0]        mem_wdata,
  input  logic                 mem_ack,
  input  logic [DW-1:0]        mem_rdata,
  input  logic [NUM_CH-1:0]    rx_valid,
  input  logic [NUM_CH-1:0]    rx_last,
  input  logic [NUM_CH*DW-1:0] rx_data,
  output logic [NUM_CH-1:0]    rx_ready,
  output logic [NUM_CH-1:0]    tx_valid,
  output logic [DW-1:0]        tx_data,
  input  logic [NUM_CH-1:0]    tx_ready
);
  logic [1:0]        rst_pipe;
  logic              rst_sn;
  logic [NUM_CH-1:0] ien_q, ien_d, ists_q, ists_d, clr_mask;
  logic [NUM_CH-1:0] ch_req, ch_wr, ch_busy, ch_done, gnt, beat_acc;
  logic [AW-1:0]     ch_addr [NUM_CH];
  logic [BEAT_B-1:0] ch_be   [NUM_CH];
  chan_cfg_t         ch_cfg  [NUM_CH];
  logic [AW-1:0]     ch_base [NUM_CH];
  logic [AW-1:0]     ch_cur  [NUM_CH];
  logic [CNT_W-1:0]  ch_len  [NUM_CH];
  logic [CNT_W-1:0]  ch_rem  [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      dmac_chan u_chan (
        .clk      (clk),
        .rst_n    (rst_sn),
        .cfg_we   (reg_we && (reg_addr == ch_ofs(c, OFS_CFG))),
        .base_we  (reg_we && (reg_addr == ch_ofs(c, OFS_BASE))),
        .len_we   (reg_we && (reg_addr == ch_ofs(c, OFS_LEN))),
        .run_we   (reg_we && (reg_addr == ch_ofs(c, OFS_RUN))),
        .wdata    (reg_wdata),
        .beat_acc (beat_acc[c]),
        .rx_valid (rx_valid[c]),
        .rx_last  (rx_last[c]),
        .tx_ready (tx_ready[c]),
        .req      (ch_req[c]),
        .req_write(ch_wr[c]),
        .req_addr (ch_addr[c]),
        .req_be   (ch_be[c]),
        .busy     (ch_busy[c]),
        .done     (ch_done[c]),
        .cfg      (ch_cfg[c]),
        .base     (ch_base[c]),
        .len      (ch_len[c]),
        .cur_addr (ch_cur[c]),
        .cur_len  (ch_rem[c])
      );
      assign beat_acc[c] = gnt[c] && mem_ack;
      assign rx_ready[c] = beat_acc[c] && ch_wr[c];
      assign tx_valid[c] = beat_acc[c] && !ch_wr[c];

      // R7
      sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
        (ists_q[c] && !clr_mask[c]) |=> ists_q[c]);
      // R6
      done_sets_chk: assert property (@(posedge clk) disable iff (!rst_sn)
        ch_done[c] |=> ists_q[c]);
    end
  endgenerate

  dmac_arb #(.N(NUM_CH)) u_arb (
    .clk  (clk),
    .rst_n(rst_sn),
    .req  (ch_req),
    .acc  (mem_ack),
    .gnt  (gnt)
  );

  always_comb begin
    mem_write = 1'b0;
    mem_addr  = '0;
    mem_be    = '0;
    mem_wdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (gnt[i]) begin
        mem_write = ch_wr[i];
        mem_addr  = ch_addr[i];
        mem_be    = ch_be[i];
        mem_wdata = rx_data[i*DW +: DW];
      end
    end
  end
  assign mem_req = |ch_req;
  assign tx_data = mem_rdata;

  always_comb begin
    clr_mask = (reg_we && (reg_addr == OFS_ICLR)) ? reg_wdata[NUM_CH-1:0] : '0;
    ien_d    = (reg_we && (reg_addr == OFS_IEN)) ? reg_wdata[NUM_CH-1:0] : ien_q;
    ists_d   = (ists_q & ~clr_mask) | ch_done;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ien_q  <= '0;
      ists_q <= '0;
    end else begin
      ien_q  <= ien_d;
      ists_q <= ists_d;
    end
  end

  assign irq = |(ists_q & ien_q);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_IEN)  reg_rdata = DW'(ien_q);
    if (reg_addr == OFS_ISTS) reg_rdata = DW'(ists_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr == ch_ofs(i, OFS_CFG))  reg_rdata = cfg_pack(ch_cfg[i]);
      if (reg_addr == ch_ofs(i, OFS_BASE)) reg_rdata = ch_base[i];
      if (reg_addr == ch_ofs(i, OFS_LEN))  reg_rdata = DW'(ch_len[i]);
      if (reg_addr == ch_ofs(i, OFS_CUR))  reg_rdata = ch_cur[i];
      if (reg_addr == ch_ofs(i, OFS_REM))  reg_rdata = DW'(ch_rem[i]);
      if (reg_addr == ch_ofs(i, OFS_RUN))  reg_rdata = DW'(ch_busy[i]);
    end
  end

  // R4
  be_low_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_req |-> mem_be[0]);
endmodule

// File: tb/dma2ch_ctrl_tb_top.sv
module dma2ch_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, mem_req, mem_write, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, tx_data;
  logic [3:0]  mem_be;
  logic [1:0]  rx_valid, rx_last, rx_ready, tx_valid, tx_ready;
  logic [63:0] rx_data;

  always #2 clk = ~clk;

  dma2ch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .rx_valid(rx_valid), .rx_last(rx_last),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready)
  );

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  be;
  } wr_t;

  wr_t         wq0[$], wq1[$], got;
  logic [31:0] tq[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  int rxc0 = 0, rxc1 = 0, ex0 = 0, ex1 = 0, last_at0 = -1;
  int arb_n = 0, last_tx_cyc = 0;
  bit arb_on = 0, gap_on = 0, tx_seen = 0, fin = 0;
  logic prev_ch;
  logic [31:0] v;

  assign rx_data   = {32'hB000_0000 + 32'(rxc1), 32'hA000_0000 + 32'(rxc0)};
  assign rx_last   = {1'b0, (rxc0 == last_at0)};
  assign mem_rdata = mem_addr ^ 32'h5A5A_0000;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rx_ready[0]) rxc0 <= rxc0 + 1;
    if (rx_ready[1]) rxc1 <= rxc1 + 1;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack && mem_write) begin
      if (rx_ready[1] ? (wq1.size() == 0) : (wq0.size() == 0)) begin
        chk("R8 R4 unexpected write", mem_addr, 32'hFFFF_FFFF);
      end else begin
        got = rx_ready[1] ? wq1.pop_front() : wq0.pop_front();
        chk("R4 write addr", mem_addr, got.a);
        chk("R4 write data", mem_wdata, got.d);
        chk("R4 byte enables", {28'h0, mem_be}, {28'h0, got.be});
      end
      if (arb_on) begin
        if (arb_n > 0) chk("R12 alternation", {31'h0, rx_ready[1]}, {31'h0, !prev_ch});
        prev_ch = rx_ready[1];
        arb_n++;
      end
    end
    if (rst_n && tx_valid[0]) chk("R5 unexpected tx ch0", tx_data, 32'hFFFF_FFFF);
    if (rst_n && tx_valid[1]) begin
      chk("R5 read beat", {31'h0, mem_write}, 32'h0);
      if (tq.size() == 0) chk("R5 unexpected tx", tx_data, 32'hFFFF_FFFF);
      else chk("R5 tx data", tx_data, tq.pop_front());
      if (gap_on && tx_seen) chk("R10 beat gap", 32'(cyc - last_tx_cyc), 32'd3);
      last_tx_cyc = cyc;
      tx_seen = 1;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle(input logic [7:0] a);
    logic [31:0] x;
    for (int i = 0; i < 400; i++) begin
      rd(a, x);
      if (x == 0) break;
    end
  endtask

  // driver: pushes expected memory writes
  task automatic push_rx(input int ch, input logic [31:0] base, input int len);
    wr_t e;
    int rem = len;
    logic [31:0] a = base;
    while (rem > 0) begin
      int n = (rem >= 4) ? 4 : rem;
      e.a  = a;
      e.be = 4'((1 << n) - 1);
      if (ch == 0) begin e.d = 32'hA000_0000 + 32'(ex0); ex0++; wq0.push_back(e); end
      else         begin e.d = 32'hB000_0000 + 32'(ex1); ex1++; wq1.push_back(e); end
      a   = a + 32'(n);
      rem = rem - n;
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    mem_ack = 1'b1; rx_valid = '0; tx_ready = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    rd(8'h30, v); chk("R1 run reg", v, 0);
    rd(8'h24, v); chk("R1 ch1 current addr", v, 0);
    rd(8'h44, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'h0, irq}, 0);
    chk("R1 mem_req", {31'h0, mem_req}, 0);

    // R2 R3 R11 programming and start
    wr(8'h40, 1);
    wr(8'h00, 0); wr(8'h10, 32'h1000); wr(8'h18, 10);
    rd(8'h10, v); chk("R2 start addr", v, 32'h1000);
    rd(8'h18, v); chk("R2 length", v, 10);
    wr(8'h30, 1);
    rd(8'h30, v); chk("R3 run reads 1", v, 1);
    rd(8'h20, v); chk("R3 current addr", v, 32'h1000);
    rd(8'h28, v); chk("R3 current length", v, 10);
    wr(8'h10, 32'h5555);
    rd(8'h10, v); chk("R11 addr write ignored", v, 32'h1000);
    wr(8'h00, 32'h1000);
    rd(8'h00, v); chk("R11 config write ignored", v, 0);

    // R4 R6 receive transfer with partial tail
    push_rx(0, 32'h1000, 10);
    rx_valid[0] = 1'b1;
    wait_idle(8'h30);
    rx_valid[0] = 1'b0;
    chk("R4 all writes seen", 32'(wq0.size()), 0);
    rd(8'h20, v); chk("R6 end addr", v, 32'h100A);
    rd(8'h28, v); chk("R4 current length", v, 0);
    rd(8'h44, v); chk("R6 status", v, 1);
    chk("R7 irq raised", {31'h0, irq}, 1);

    // R7 persistence and clear
    wr(8'h30, 0);
    rd(8'h44, v); chk("R7 status persists", v, 1);
    wr(8'h48, 1);
    rd(8'h44, v); chk("R7 status cleared", v, 0);
    chk("R7 irq dropped", {31'h0, irq}, 0);

    // R5 R10 transmit on channel 1 with wait 2
    wr(8'h04, 32'h1020);
    rd(8'h04, v); chk("R2 ch1 config", v, 32'h1020);
    wr(8'h14, 32'h2000); wr(8'h1C, 8);
    tq.push_back(32'h2000 ^ 32'h5A5A_0000);
    tq.push_back(32'h2004 ^ 32'h5A5A_0000);
    tx_ready[1] = 1'b1; gap_on = 1;
    wr(8'h34, 1);
    wait_idle(8'h34);
    tx_ready[1] = 1'b0; gap_on = 0;
    chk("R5 all reads seen", 32'(tq.size()), 0);
    rd(8'h2C, v); chk("R5 ch1 current length", v, 0);
    rd(8'h44, v); chk("R6 ch1 status", v, 2);
    chk("R7 masked irq", {31'h0, irq}, 0);
    wr(8'h40, 3);
    rd(8'h44, v); chk("R7 unmasked irq", {31'h0, irq}, 1);
    wr(8'h48, 2); wr(8'h40, 1);

    // R6 zero length
    rx_valid[0] = 1'b1;
    wr(8'h10, 32'h4000); wr(8'h18, 0); wr(8'h30, 1);
    wait_idle(8'h30);
    rx_valid[0] = 1'b0;
    rd(8'h44, v); chk("R6 zero length status", v, 1);
    rd(8'h20, v); chk("R6 zero length addr", v, 32'h4000);
    wr(8'h48, 1);

    // R8 halt
    wr(8'h18, 100); wr(8'h30, 1); wr(8'h30, 0);
    rd(8'h30, v); chk("R8 halted", v, 0);
    rx_valid[0] = 1'b1;
    repeat (10) @(posedge clk);
    rx_valid[0] = 1'b0;
    rd(8'h44, v); chk("R8 no status", v, 0);
    rd(8'h28, v); chk("R8 length kept", v, 100);

    // R9 receive-end mode
    wr(8'h00, 32'h100); wr(8'h10, 32'h5000); wr(8'h18, 40);
    last_at0 = rxc0 + 2;
    push_rx(0, 32'h5000, 12);
    rx_valid[0] = 1'b1;
    wr(8'h30, 1);
    wait_idle(8'h30);
    rx_valid[0] = 1'b0; last_at0 = -1;
    chk("R9 three writes", 32'(wq0.size()), 0);
    rd(8'h28, v); chk("R9 residue", v, 28);
    rd(8'h20, v); chk("R9 stop addr", v, 32'h500C);
    rd(8'h44, v); chk("R9 status", v, 1);
    wr(8'h48, 1); wr(8'h00, 0);

    // R12 both channels
    wr(8'h04, 0); wr(8'h14, 32'h6000); wr(8'h1C, 8);
    wr(8'h10, 32'h7000); wr(8'h18, 8);
    push_rx(0, 32'h7000, 8);
    push_rx(1, 32'h6000, 8);
    wr(8'h30, 1); wr(8'h34, 1);
    arb_on = 1; arb_n = 0;
    rx_valid = 2'b11;
    wait_idle(8'h30); wait_idle(8'h34);
    rx_valid = 2'b00; arb_on = 0;
    chk("R12 beats seen", 32'(wq0.size() + wq1.size()), 0);
    chk("R12 beat count", 32'(arb_n), 4);
    rd(8'h44, v); chk("R12 both status", v, 3);
    wr(8'h48, 3);

    // R7 completion and clear on the same edge
    wr(8'h10, 32'h3000); wr(8'h18, 4);
    push_rx(0, 32'h3000, 4);
    rx_valid[0] = 1'b1;
    wr(8'h30, 1);
    wr(8'h48, 1);
    rx_valid[0] = 1'b0;
    rd(8'h44, v); chk("R7 set wins over clear", v, 1);
    rd(8'h30, v); chk("R6 done after one beat", v, 0);
    wr(8'h48, 1);
    rd(8'h44, v); chk("R7 later clear", v, 0);

    fin = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule